// File: doc/BRIEF.md
# OTP Direct-Access Word Read Assembler

This block sits between a host that wants 32-bit words out of one-time-programmable memory and a memory whose physical words are 16 data bits plus 6 check bits wide. The host gives a 32-bit word address and pulses a request. The block turns the word address into a byte address and then into a memory word index. It reads the two neighbouring memory words one after the other and joins their data halves into one 32-bit little-endian result.

The check bits are not corrected here. The two 6-bit fields are packed side by side and returned with the data so that a separate checker can use them. The host sees a busy flag while a read is in flight and a one-cycle valid pulse when the result is ready. On the memory side there is a synchronous read port with one cycle of latency.

Top module: `otp_word_reader`

## Requirements
- R1: After reset, `busy_o`, `valid_o` and `mem_en_o` are low.
- R2: On an accepted request, `byte_addr_o` becomes the word address times four. It holds that value until the next accepted request.
- R3: The first memory read uses index byte address / 2, which is twice the word address. The second read uses that index plus one. For example, word address 0xFE gives byte address 0x3F8 and memory words 0x1FC then 0x1FD.
- R4: The data of the first memory word appears on `rdata_o[15:0]` and the data of the second on `rdata_o[31:16]`. Memory words 0xa877 then 0xb17c give 0xb17ca877.
- R5: `recc_o[5:0]` carries bits [21:16] of the first memory word and `recc_o[11:6]` carries bits [21:16] of the second.
- R6: A request is accepted on an edge where `busy_o` is low. `busy_o` is then high for exactly three cycles. `valid_o` is high for the single cycle after that, with `busy_o` low.
- R7: A request raised while `busy_o` is high is ignored. It does not change the addresses, the result, or the length of the read in progress, and it starts no read of its own.
- R8: A request raised during the cycle in which `valid_o` is high is accepted, so reads can follow each other with no idle cycle.
- R9: `mem_en_o` is high only in the first two busy cycles of each read, one cycle per memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Read request |
| word_addr_i | input | ADDR_W | 32-bit word address |
| busy_o | output | 1 | Read in flight |
| valid_o | output | 1 | One-cycle result strobe |
| byte_addr_o | output | ADDR_W+2 | Byte address of the accepted request |
| rdata_o | output | 32 | Assembled read data |
| recc_o | output | 12 | Raw check bits, second word in the upper half |
| mem_en_o | output | 1 | Memory read enable |
| mem_addr_o | output | ADDR_W+1 | Memory word index |
| mem_rdata_i | input | 22 | Memory word: check bits [21:16], data [15:0] |

## Verification
Two events can fall in the same cycle: the completion strobe of one read and the acceptance of the next request. The bench raises a new request with a different address during the exact cycle in which `valid_o` is high. It checks that the first result is correct in that cycle. It then checks that the next cycle already shows busy and the new memory index, and that the second result arrives four edges later. A request held high through all the busy cycles is also checked: it must leave the addresses and the cycle count of the read in progress unchanged.

// File: rtl/otp_word_reader.sv
module otp_word_reader #(
  parameter int ADDR_W = 8,
  parameter int DW     = 16,
  parameter int EW     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   word_addr_i,
  output logic                busy_o,
  output logic                valid_o,
  output logic [ADDR_W+1:0]   byte_addr_o,
  output logic [2*DW-1:0]     rdata_o,
  output logic [2*EW-1:0]     recc_o,
  output logic                mem_en_o,
  output logic [ADDR_W:0]     mem_addr_o,
  input  logic [DW+EW-1:0]    mem_rdata_i
);

  typedef enum logic [1:0] {IDLE, RD_LO, RD_HI, FIN} st_t;
  st_t state;
  logic [DW+EW-1:0] lo_q;

  assign busy_o     = (state != IDLE);
  assign mem_en_o   = (state == RD_LO) || (state == RD_HI);
  assign mem_addr_o = byte_addr_o[ADDR_W+1:1] | {{ADDR_W{1'b0}}, state == RD_HI};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= IDLE;
      valid_o     <= 1'b0;
      byte_addr_o <= '0;
      lo_q        <= '0;
      rdata_o     <= '0;
      recc_o      <= '0;
    end else begin
      valid_o <= 1'b0;
      case (state)
        IDLE: if (req_i) begin
          byte_addr_o <= {word_addr_i, 2'b00};
          state       <= RD_LO;
        end
        RD_LO: state <= RD_HI;
        RD_HI: begin
          lo_q  <= mem_rdata_i;
          state <= FIN;
        end
        default: begin
          rdata_o <= {mem_rdata_i[DW-1:0], lo_q[DW-1:0]};
          recc_o  <= {mem_rdata_i[DW+EW-1:DW], lo_q[DW+EW-1:DW]};
          valid_o <= 1'b1;
          state   <= IDLE;
        end
      endcase
    end
  end

  a_r1_mem_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en_o |-> busy_o);
  a_r6_valid_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && busy_o));
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r3_second_index: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && $past(mem_en_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));
  a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(byte_addr_o));
  a_r9_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && $past(mem_en_o)) |=> !mem_en_o);

endmodule

// File: tb/test_otp_word_reader.sv
module test_otp_word_reader;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic busy, valid, mem_en;
  logic [AW+1:0] baddr;
  logic [31:0] rdata;
  logic [11:0] recc;
  logic [AW:0] maddr;
  logic [21:0] mrd;
  logic [21:0] mem [2**(AW+1)];
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  otp_word_reader #(.ADDR_W(AW)) i_otp_word_reader (
    .clk(clk), .rst_n(rst_n), .req_i(req), .word_addr_i(waddr),
    .busy_o(busy), .valid_o(valid), .byte_addr_o(baddr),
    .rdata_o(rdata), .recc_o(recc), .mem_en_o(mem_en),
    .mem_addr_o(maddr), .mem_rdata_i(mrd));

  always_ff @(posedge clk) if (mem_en) mrd <= mem[maddr];

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  // Runs one read; if pre is set the request is already being driven.
  // Leaves at the falling edge of the valid cycle. hold keeps a stray request up while busy.
  task automatic run_read(input logic [AW-1:0] a, input bit pre, input bit hold, input logic [AW-1:0] other);
    logic [AW:0] lo = {a, 1'b0};
    if (!pre) begin
      @(negedge clk); req = 1'b1; waddr = a;
    end
    @(negedge clk);
    req = hold; waddr = other;
    chk(busy && mem_en, "R6 busy/en c1", {busy, mem_en}, 2'b11);
    chk(baddr == {a, 2'b00}, "R2 byte addr", baddr, {a, 2'b00});
    chk(maddr == lo, "R3 first index", maddr, lo);
    @(negedge clk);
    chk(busy && mem_en && maddr == lo + 1'b1, "R3 second index", maddr, lo + 1'b1);
    @(negedge clk);
    chk(busy && !mem_en && !valid, "R9 en low c3", {busy, mem_en, valid}, 3'b100);
    chk(baddr == {a, 2'b00}, "R7 byte addr held", baddr, {a, 2'b00});
    @(negedge clk);
    req = 1'b0;
    chk(valid && !busy, "R6 valid pulse", {valid, busy}, 2'b10);
    chk(rdata == {mem[lo+1][15:0], mem[lo][15:0]}, "R4 data", rdata, {mem[lo+1][15:0], mem[lo][15:0]});
    chk(recc == {mem[lo+1][21:16], mem[lo][21:16]}, "R5 ecc", recc, {mem[lo+1][21:16], mem[lo][21:16]});
  endtask

  task automatic t_reset;
    chk(!busy && !valid && !mem_en, "R1 reset", {busy, valid, mem_en}, 3'b000);
  endtask

  task automatic t_example;
    run_read(8'hFE, 1'b0, 1'b0, 8'h00);
    chk(rdata == 32'hb17ca877, "R4 example", rdata, 32'hb17ca877);
    chk(recc == {6'h10, 6'h1f}, "R5 example", recc, {6'h10, 6'h1f});
    @(negedge clk);
    chk(!valid && !busy, "R6 idle after", {valid, busy}, 2'b00);
  endtask

  task automatic t_patterns;
    run_read(8'h00, 1'b0, 1'b0, 8'h00);
    run_read(8'hFF, 1'b0, 1'b0, 8'h00);
    run_read(8'h55, 1'b0, 1'b0, 8'h00);
    run_read(8'hA3, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
  endtask

  task automatic t_busy_ignore;
    run_read(8'h12, 1'b0, 1'b1, 8'h77);
    @(negedge clk);
    chk(!busy && !mem_en, "R7 stray req ignored", {busy, mem_en}, 2'b00);
    chk(baddr == {8'h12, 2'b00}, "R7 addr unchanged", baddr, {8'h12, 2'b00});
  endtask

  task automatic t_back_to_back;
    run_read(8'h30, 1'b0, 1'b0, 8'h00);
    req = 1'b1; waddr = 8'hC1;
    run_read(8'hC1, 1'b1, 1'b0, 8'h00);
    chk(rdata == {mem[9'h183][15:0], mem[9'h182][15:0]}, "R8 chained data", rdata, {mem[9'h183][15:0], mem[9'h182][15:0]});
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 2**(AW+1); i++)
      mem[i] = {6'(i * 7 + 3), 16'(i * 16'h9e37) ^ 16'h5a5a};
    mem[9'h1FC] = {6'h1f, 16'ha877};
    mem[9'h1FD] = {6'h10, 16'hb17c};
    #5;
    t_reset;
    #40 rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_example;
    t_patterns;
    t_busy_ignore;
    t_back_to_back;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule